// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is a private event timer for one processor core. It sits behind a 256-byte register window that the interconnect decodes; only the low eight address bits reach the block, and the window base per core is set where the block is instantiated. Two counters are chained. A prescaler divides the clock by a programmable tick divider plus one. An interrupt counter then counts those ticks and raises an interrupt when it runs out, reloading itself from a reload register.

Software programs the divider first. It then writes the reload value with the update request bit set, enables the interrupt line, and sets the start bits in the control register. The interrupt is acknowledged by writing one to the status register. Each write to the divider, reload or control register leaves a confirmation bit in a write-status register, which software clears by writing one to it. Interval mode repeats the interrupt until the timer is stopped. One-shot mode fires a single interrupt per update.

Top module: `core_tick_timer`

## Requirements
- R1: After reset, every readable register (offsets 0x00, 0x08, 0x20, 0x30, 0x34, 0x40) reads zero and `irq` is low.
- R2: With the timer and interrupt counting started, interval mode on and a reload value R loaded, the prescaler produces one tick every D+1 cycles, where D is the divider at offset 0x00. The first interrupt after a start from prescaler value zero comes (R+2)(D+1) cycles after the control write, because the first tick loads the counter. Interrupts then repeat every (R+1)(D+1) cycles.
- R3: A write to offset 0x08 with bit 31 set stores bits 30:0 as the reload value and raises an update flag that reads back in bit 31. The flag clears on the first tick boundary at which interrupt counting is active, and the reload value is copied into the counter at that boundary.
- R4: A write to offset 0x08 with bit 31 clear leaves both the reload value and the update flag unchanged.
- R5: Control register at offset 0x20: bit 0 runs the prescaler, bit 1 allows the interrupt counter to advance, and bit 2 selects interval mode. With bit 1 clear, a pending update is not taken and no interrupt is raised.
- R6: With control bit 2 clear (one-shot), the counter raises exactly one interrupt after an update and then stays idle until the next update.
- R7: Clearing control bit 0 freezes both counters and leaves the pending status as it was. Setting it again resumes the remaining count exactly.
- R8: Status bit 0 at offset 0x30 is set when the counter expires and is cleared only by writing one to it. Writing zero has no effect.
- R9: `irq` is high exactly when status bit 0 is set and enable bit 0 at offset 0x34 is set.
- R10: Write-status bits at offset 0x40 are set by writes to the divider (bit 0), the reload register (bit 1) and control (bit 3). Each bit is cleared by writing one to that bit position.
- R11: A reload value of zero raises an interrupt on every tick, so the period is D+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request to this core |

## Verification
The assertions assume that reset is held for at least one clock edge and that the bus inputs are known whenever reset is released. They also assume that a write occupies exactly one cycle with `bus_addr` and `bus_wdata` stable across that edge, because the write-status property looks at the read port one cycle after a control write. The bench respects this by driving every bus signal on the falling edge and dropping the strobe after a single rising edge. It changes the divider only while the timer is stopped, and it reads through the combinational read port without issuing a write.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;

    // Byte offsets inside the per-core window; software decodes these.
    localparam logic [BUS_AW-1:0] OFS_DIV  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_RLD  = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_STAT = 8'h30;
    localparam logic [BUS_AW-1:0] OFS_IEN  = 8'h34;
    localparam logic [BUS_AW-1:0] OFS_WST  = 8'h40;

    // Write-status bit positions.
    localparam int unsigned WST_DIV  = 0;
    localparam int unsigned WST_RLD  = 1;
    localparam int unsigned WST_CTRL = 3;
    localparam int unsigned WST_W    = 4;

    // Bit 31 of a reload write requests the transfer.
    localparam int unsigned UPD_BIT = 31;

    typedef struct packed {
        logic interval;   // bit 2
        logic cnt_run;    // bit 1
        logic tmr_run;    // bit 0
    } ctrl_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] div,
    output logic              tick
);

    typedef struct packed {
        logic [TICK_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // >= keeps the divider safe if it is ever lowered mid-count
        tick = run && (st_q.pre >= div);
        if (run) begin
            if (tick) begin
                st_d.pre = '0;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tick_intcnt.sv
module tick_intcnt #(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_run,
    input  logic             interval,
    input  logic [CNT_W-1:0] reload,
    input  logic             upd_pend,
    output logic             fire,
    output logic             upd_taken
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d      = st_q;
        fire      = 1'b0;
        step      = tick && cnt_run;
        upd_taken = step && upd_pend;
        if (step) begin
            if (upd_pend) begin
                st_d.cnt   = reload;
                st_d.armed = 1'b1;
            end else if (st_q.armed) begin
                if (st_q.cnt == '0) begin
                    fire     = 1'b1;
                    st_d.cnt = reload;
                    if (!interval) begin
                        st_d.armed = 1'b0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int unsigned TICK_W = 32,
    parameter int unsigned CNT_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              fire,
    input  logic              upd_taken,
    output logic [TICK_W-1:0] div,
    output logic [CNT_W-1:0]  reload,
    output logic              upd_pend,
    output ctrl_t             ctrl,
    output logic              stat,
    output logic              ien
);

    typedef struct packed {
        logic [TICK_W-1:0] div;
        logic [CNT_W-1:0]  reload;
        logic              upd_pend;
        ctrl_t             ctrl;
        logic              stat;
        logic              ien;
        logic [WST_W-1:0]  wst;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_taken) begin
            st_d.upd_pend = 1'b0;
        end
        if (bus_wr) begin
            case (bus_addr)
                OFS_DIV: begin
                    st_d.div          = bus_wdata[TICK_W-1:0];
                    st_d.wst[WST_DIV] = 1'b1;
                end
                OFS_RLD: begin
                    st_d.wst[WST_RLD] = 1'b1;
                    if (bus_wdata[UPD_BIT]) begin
                        st_d.reload   = bus_wdata[CNT_W-1:0];
                        st_d.upd_pend = 1'b1;
                    end
                end
                OFS_CTRL: begin
                    st_d.ctrl          = ctrl_t'(bus_wdata[2:0]);
                    st_d.wst[WST_CTRL] = 1'b1;
                end
                OFS_STAT: begin
                    if (bus_wdata[0]) begin
                        st_d.stat = 1'b0;
                    end
                end
                OFS_IEN: begin
                    st_d.ien = bus_wdata[0];
                end
                OFS_WST: begin
                    st_d.wst = st_q.wst & ~bus_wdata[WST_W-1:0];
                end
                default: ;
            endcase
        end
        // An expiry in the same cycle as an acknowledge wins.
        if (fire) begin
            st_d.stat = 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DIV:  bus_rdata = BUS_DW'(st_q.div);
            OFS_RLD: begin
                bus_rdata          = BUS_DW'(st_q.reload);
                bus_rdata[UPD_BIT] = st_q.upd_pend;
            end
            OFS_CTRL: bus_rdata = BUS_DW'(st_q.ctrl);
            OFS_STAT: bus_rdata = BUS_DW'(st_q.stat);
            OFS_IEN:  bus_rdata = BUS_DW'(st_q.ien);
            OFS_WST:  bus_rdata = BUS_DW'(st_q.wst);
            default:  bus_rdata = '0;
        endcase
    end

    assign div      = st_q.div;
    assign reload   = st_q.reload;
    assign upd_pend = st_q.upd_pend;
    assign ctrl     = st_q.ctrl;
    assign stat     = st_q.stat;
    assign ien      = st_q.ien;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import tick_pkg::*;
#(
    parameter int unsigned TICK_W = 32,
    parameter int unsigned CNT_W  = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    logic [TICK_W-1:0] div;
    logic [CNT_W-1:0]  reload;
    logic              upd_pend;
    ctrl_t             ctrl;
    logic              stat;
    logic              ien;
    logic              tick;
    logic              fire;
    logic              upd_taken;

    tick_regs #(
        .TICK_W (TICK_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fire      (fire),
        .upd_taken (upd_taken),
        .div       (div),
        .reload    (reload),
        .upd_pend  (upd_pend),
        .ctrl      (ctrl),
        .stat      (stat),
        .ien       (ien)
    );

    tick_prescaler #(
        .TICK_W (TICK_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.tmr_run),
        .div   (div),
        .tick  (tick)
    );

    tick_intcnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_run   (ctrl.cnt_run),
        .interval  (ctrl.interval),
        .reload    (reload),
        .upd_pend  (upd_pend),
        .fire      (fire),
        .upd_taken (upd_taken)
    );

    assign irq = stat && ien;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq,
    input logic        tick,
    input logic        tmr_run,
    input logic        cnt_run,
    input logic        upd_pend,
    input logic        stat
);

    logic ack_wr;
    logic rld_upd_wr;
    assign ack_wr     = bus_wr && (bus_addr == 8'h30) && bus_wdata[0];
    assign rld_upd_wr = bus_wr && (bus_addr == 8'h08) && bus_wdata[31];

    // R2: status can only rise on an edge where the prescaler ticked
    p_stat_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> $past(tick));

    // R3: an active tick consumes the pending update
    p_update_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_run && upd_pend && !rld_upd_wr) |=> !upd_pend);

    // R5: without counting enabled, a pending update survives a tick
    p_update_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_run && upd_pend) |=> upd_pend);

    // R7: a stopped timer produces no ticks
    p_no_tick_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_run |-> !tick);

    // R7, R8: status holds while no tick and no acknowledge
    p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ack_wr) |=> $stable(stat));

    // R9: disabling the line drops irq on the next cycle
    p_irq_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h34 && !bus_wdata[0]) |=> !irq);

    // R9: irq never without pending status
    p_irq_needs_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat);

    // R10: a control write is confirmed in write-status bit 3
    p_wstat_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h20) ##1 (bus_addr == 8'h40) |-> bus_rdata[3]);

endmodule

bind core_tick_timer tick_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tick      (tick),
    .tmr_run   (ctrl.tmr_run),
    .cnt_run   (ctrl.cnt_run),
    .upd_pend  (upd_pend),
    .stat      (stat)
);

// File: tb/core_tick_timer_tb.sv
`timescale 1ns/100ps
module core_tick_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    localparam int D  = 2;
    localparam int R  = 3;
    localparam int LIM = 5000;

    always #2.5 clk = ~clk;

    core_tick_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called on a falling edge; consumes one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // falling edges until irq is seen
    task automatic wait_irq(output int cnt);
        cnt = 0;
        while (!irq && cnt < LIM) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", 32'(irq), 32'd0);
        rd(8'h00, v); chk("R1 div", v, 0);
        rd(8'h08, v); chk("R1 reload", v, 0);
        rd(8'h20, v); chk("R1 ctrl", v, 0);
        rd(8'h30, v); chk("R1 stat", v, 0);
        rd(8'h34, v); chk("R1 ien", v, 0);
        rd(8'h40, v); chk("R1 wstat", v, 0);
    endtask

    task automatic t_wstat;
        logic [31:0] v;
        wr(8'h00, D);
        rd(8'h40, v); chk("R10 div write", v, 32'h1);
        rd(8'h00, v); chk("R2 div readback", v, D);
        wr(8'h08, 32'h8000_0000 | R);
        rd(8'h40, v); chk("R10 reload write", v, 32'h3);
        wr(8'h40, 32'h1);
        rd(8'h40, v); chk("R10 clear bit0", v, 32'h2);
        wr(8'h20, 32'h0);
        rd(8'h40, v); chk("R10 ctrl write", v, 32'ha);
        wr(8'h40, 32'h0);
        rd(8'h40, v); chk("R10 write zero", v, 32'ha);
        wr(8'h40, 32'hf);
        rd(8'h40, v); chk("R10 clear all", v, 32'h0);
    endtask

    task automatic t_update_flag;
        logic [31:0] v;
        rd(8'h08, v); chk("R3 flag set", v, 32'h8000_0000 | R);
        wr(8'h08, 32'h0000_0009);
        rd(8'h08, v); chk("R4 write ignored", v, 32'h8000_0000 | R);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        int c;
        wr(8'h34, 32'h1);
        wr(8'h20, 32'h7);
        wait_irq(c);
        chk("R2 first interrupt", c, (R + 2) * (D + 1));
        rd(8'h08, v); chk("R3 flag cleared", v, R);
        wr(8'h30, 32'h1);
        chk("R8 cleared", 32'(irq), 0);
        wait_irq(c);
        chk("R2 period", c, (R + 1) * (D + 1) - 1);
    endtask

    task automatic t_freeze;
        logic [31:0] v;
        int c;
        wr(8'h20, 32'h0);
        rd(8'h30, v); chk("R7 status kept", v, 1);
        wr(8'h30, 32'h1);
        repeat (60) @(negedge clk);
        chk("R7 frozen no irq", 32'(irq), 0);
        rd(8'h30, v); chk("R7 frozen status", v, 0);
        wr(8'h20, 32'h7);
        wait_irq(c);
        chk("R7 resumed remainder", c, (R + 1) * (D + 1) - 1);
    endtask

    task automatic t_zero_reload;
        logic [31:0] v;
        int c;
        wr(8'h20, 32'h0);
        wr(8'h08, 32'h8000_0000);
        rd(8'h08, v); chk("R3 pending while stopped", v, 32'h8000_0000);
        wr(8'h20, 32'h7);
        repeat (25) @(negedge clk);
        rd(8'h08, v); chk("R3 taken", v, 32'h0);
        wr(8'h30, 32'h1);
        wait_irq(c);
        wr(8'h30, 32'h1);
        wait_irq(c);
        chk("R11 every tick", c, D);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        int c;
        wr(8'h20, 32'h0);
        wr(8'h30, 32'h1);
        wr(8'h08, 32'h8000_0002);
        wr(8'h20, 32'h3);
        wait_irq(c);
        chk("R6 one interrupt", 32'(c > 0 && c <= 4 * (D + 1)), 1);
        wr(8'h30, 32'h1);
        repeat (100) @(negedge clk);
        chk("R6 no repeat irq", 32'(irq), 0);
        rd(8'h30, v); chk("R6 no repeat status", v, 0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(8'h34, 32'h0);
        wr(8'h08, 32'h8000_0001);
        wr(8'h20, 32'h7);
        repeat (40) @(negedge clk);
        rd(8'h30, v); chk("R9 status set", v, 1);
        chk("R9 masked", 32'(irq), 0);
        wr(8'h20, 32'h0);
        wr(8'h30, 32'h0);
        rd(8'h30, v); chk("R8 write zero", v, 1);
        wr(8'h34, 32'h1);
        chk("R9 unmasked", 32'(irq), 1);
        wr(8'h30, 32'h1);
        chk("R8 acknowledge", 32'(irq), 0);
    endtask

    task automatic t_count_gate;
        logic [31:0] v;
        wr(8'h08, 32'h8000_0001);
        wr(8'h20, 32'h1);
        repeat (40) @(negedge clk);
        rd(8'h08, v); chk("R5 update held", v, 32'h8000_0001);
        rd(8'h30, v); chk("R5 no status", v, 0);
        wr(8'h20, 32'h3);
        repeat (20) @(negedge clk);
        rd(8'h08, v); chk("R5 update taken", v, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wstat();
        t_update_flag();
        t_periodic();
        t_freeze();
        t_zero_reload();
        t_oneshot();
        t_enable();
        t_count_gate();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule